// File: doc/BRIEF.md
# Synthesizer Control Register Bank

This block holds the programming state for a pair of frequency synthesizers. A two-wire serial front end delivers bytes to it. That front end handles the bit-level protocol, clock stretching and address sensing, and it reports each transaction edge as a one-cycle start or stop strobe. The first byte after a start is a device address. The block compares it with an address chosen by a 3-bit strap code. If they match, each following group of three bytes forms one 24-bit control word, most significant byte first.

The two low bits of each completed word say where it goes. It is written to either the main (A/B counter) register or the reference divider register of either synthesizer. Main and reference words place their fields differently. The block decodes both layouts into parallel outputs and raises a one-cycle update flag for the register it writes.

Bytes arrive on a valid/ready stream. The block never applies back-pressure: `byte_ready_o` is low only during reset and is high in every cycle after the first clock edge with reset released. A byte counts as transferred on each rising edge where both valid and ready are high. Ready does not depend on valid, and the sender may raise or drop valid in any cycle.

Top module: `synth_ctrl_bank`

## Requirements
- R1: After reset every decoded field output is zero, every update flag is low, and `byte_ready_o` is high from the first clock after reset is released.
- R2: The expected address byte follows the strap code: 0 gives 0xC2, 1 gives 0xC0, 2 gives 0xC4, 3 gives 0xC0, 4 gives 0xC6, and codes 5 to 7 also give 0xC6.
- R3: If the first byte after a start strobe differs from the expected address, every byte up to the next start strobe is ignored and no register changes.
- R4: Three accepted data bytes, first byte in bits [23:16] and third byte in bits [7:0], form one word. Bits [1:0] of the word select its destination: 00 is the synthesizer-2 reference register, 01 the synthesizer-2 main register, 10 the synthesizer-1 reference register and 11 the synthesizer-1 main register. No other register changes.
- R5: A main word decodes as mode = bits [23:22], B count = bits [21:11] and A count = bits [10:4]. Bits [3:2] are ignored.
- R6: A reference word decodes as mode = bits [21:17] and divider = bits [16:2]. Bits [23:22] are ignored.
- R7: A stop strobe that arrives before the third byte of a word discards the partial word. No register changes, and the next transaction starts over with an address byte.
- R8: The update flag of the written register is high for exactly one cycle. That is the first cycle in which the new field values appear, and at most one flag is high at a time.
- R9: Within one transaction, several words may follow one another, each routed by its own select bits.
- R10: A start or stop strobe in the same cycle as a valid byte takes priority, and that byte is dropped. A start takes priority over a stop in the same cycle.
- R11: Bytes that arrive after a stop and before the next start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle transaction start strobe |
| stop_i | input | 1 | One-cycle transaction stop strobe |
| byte_valid_i | input | 1 | Byte stream valid |
| byte_data_i | input | 8 | Byte stream data |
| byte_ready_o | output | 1 | Byte stream ready (no back-pressure) |
| strap_i | input | 3 | Address strap code |
| a_count_o | output | 2x7 | A count per synthesizer (index 0 = synthesizer 1) |
| b_count_o | output | 2x11 | B count per synthesizer |
| main_mode_o | output | 2x2 | Main register mode bits per synthesizer |
| ref_div_o | output | 2x15 | Reference divider per synthesizer |
| ref_mode_o | output | 2x5 | Reference register mode bits per synthesizer |
| main_upd_o | output | 2 | Main register update flag per synthesizer |
| ref_upd_o | output | 2 | Reference register update flag per synthesizer |

## Verification
The risky coincidence is a transaction strobe that lands in the same cycle as a word's third byte, when a commit and an abort compete. The bench drives a stop together with the final byte, and separately a start together with a data byte. In the first case it expects no update flag and unchanged fields. In the second it expects the following byte to be treated as an address. Random transactions mixing good words, bad addresses and early aborts then confirm that the register model and the outputs stay in step.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;
  localparam int BYTE_W   = 8;
  localparam int NBYTES   = 3;
  localparam int WORD_W   = BYTE_W * NBYTES;
  localparam int SEL_W    = 2;
  localparam int NREGS    = 1 << SEL_W;
  localparam int NSYN     = NREGS / 2;
  // main word layout
  localparam int A_W      = 7;
  localparam int B_W      = 11;
  localparam int MMODE_W  = 2;
  localparam int A_LSB    = 4;
  localparam int B_LSB    = A_LSB + A_W;
  localparam int MMODE_LSB = B_LSB + B_W;
  // reference word layout
  localparam int DIV_W    = 15;
  localparam int RMODE_W  = 5;
  localparam int DIV_LSB  = SEL_W;
  localparam int RMODE_LSB = DIV_LSB + DIV_W;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_DROP} rx_state_t;

  function automatic logic [BYTE_W-1:0] strap_to_addr(input logic [2:0] code);
    case (code)
      3'd0:    return 8'hC2;
      3'd1:    return 8'hC0;
      3'd2:    return 8'hC4;
      3'd3:    return 8'hC0;
      default: return 8'hC6;
    endcase
  endfunction
endpackage

// File: rtl/sc_addr_match.sv
module sc_addr_match
  import synth_ctrl_pkg::*;
(
  input  logic [2:0]        strap_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              match_o
);
  always_comb match_o = (byte_i == strap_to_addr(strap_i));
endmodule

// File: rtl/sc_word_assembler.sv
module sc_word_assembler
  import synth_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_take_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              addr_match_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int SHIFT_W = WORD_W - BYTE_W;
  localparam int CNT_W   = $clog2(NBYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  rx_state_t          state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [SHIFT_W-1:0] shift_q;
  logic               data_byte;

  always_comb begin
    data_byte    = byte_take_i && !start_i && !stop_i && (state_q == ST_DATA);
    word_valid_o = data_byte && (cnt_q == LAST);
    word_o       = {shift_q, byte_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (byte_take_i) begin
      case (state_q)
        ST_ADDR: begin
          state_q <= addr_match_i ? ST_DATA : ST_DROP;
          cnt_q   <= '0;
        end
        ST_DATA: begin
          shift_q <= {shift_q[SHIFT_W-BYTE_W-1:0], byte_i};
          cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sc_reg_slot.sv
module sc_reg_slot
  import synth_ctrl_pkg::*;
#(
  parameter int SEL_CODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o,
  output logic              upd_o
);
  logic hit;
  always_comb hit = wr_i && (word_i[SEL_W-1:0] == SEL_W'(SEL_CODE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= hit;
      if (hit) word_o <= word_i;
    end
  end
endmodule

// File: rtl/synth_ctrl_bank.sv
module synth_ctrl_bank
  import synth_ctrl_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic                           stop_i,
  input  logic                           byte_valid_i,
  input  logic [BYTE_W-1:0]              byte_data_i,
  output logic                           byte_ready_o,
  input  logic [2:0]                     strap_i,
  output logic [NSYN-1:0][A_W-1:0]       a_count_o,
  output logic [NSYN-1:0][B_W-1:0]       b_count_o,
  output logic [NSYN-1:0][MMODE_W-1:0]   main_mode_o,
  output logic [NSYN-1:0][DIV_W-1:0]     ref_div_o,
  output logic [NSYN-1:0][RMODE_W-1:0]   ref_mode_o,
  output logic [NSYN-1:0]                main_upd_o,
  output logic [NSYN-1:0]                ref_upd_o
);
  logic              ready_q;
  logic              take;
  logic              match;
  logic              word_valid;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] slot_word [NREGS];
  logic [NREGS-1:0]  slot_upd;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign byte_ready_o = ready_q;
  assign take = byte_valid_i && ready_q;

  sc_addr_match i_match (
    .strap_i (strap_i),
    .byte_i  (byte_data_i),
    .match_o (match)
  );

  sc_word_assembler i_asm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .byte_take_i  (take),
    .byte_i       (byte_data_i),
    .addr_match_i (match),
    .word_valid_o (word_valid),
    .word_o       (word)
  );

  for (genvar g = 0; g < NREGS; g++) begin : g_slot
    sc_reg_slot #(.SEL_CODE(g)) i_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (word_valid),
      .word_i (word),
      .word_o (slot_word[g]),
      .upd_o  (slot_upd[g])
    );
  end

  // synthesizer index 0 owns select codes 3/2, index 1 owns 1/0
  for (genvar s = 0; s < NSYN; s++) begin : g_syn
    localparam int MAIN_IDX = NREGS - 1 - 2 * s;
    localparam int REF_IDX  = MAIN_IDX - 1;
    assign a_count_o[s]   = slot_word[MAIN_IDX][A_LSB +: A_W];
    assign b_count_o[s]   = slot_word[MAIN_IDX][B_LSB +: B_W];
    assign main_mode_o[s] = slot_word[MAIN_IDX][MMODE_LSB +: MMODE_W];
    assign ref_div_o[s]   = slot_word[REF_IDX][DIV_LSB +: DIV_W];
    assign ref_mode_o[s]  = slot_word[REF_IDX][RMODE_LSB +: RMODE_W];
    assign main_upd_o[s]  = slot_upd[MAIN_IDX];
    assign ref_upd_o[s]   = slot_upd[REF_IDX];
  end
endmodule

// File: rtl/sc_checker.sv
module sc_checker
  import synth_ctrl_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start_i,
  input logic                         stop_i,
  input logic                         byte_valid_i,
  input logic [BYTE_W-1:0]            byte_data_i,
  input logic                         byte_ready_o,
  input logic [2:0]                   strap_i,
  input logic [NSYN-1:0][A_W-1:0]     a_count_o,
  input logic [NSYN-1:0][B_W-1:0]     b_count_o,
  input logic [NSYN-1:0][MMODE_W-1:0] main_mode_o,
  input logic [NSYN-1:0][DIV_W-1:0]   ref_div_o,
  input logic [NSYN-1:0][RMODE_W-1:0] ref_mode_o,
  input logic [NSYN-1:0]              main_upd_o,
  input logic [NSYN-1:0]              ref_upd_o
);
  logic any_upd;
  assign any_upd = |{main_upd_o, ref_upd_o};

  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> byte_ready_o);

  a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({main_upd_o, ref_upd_o}));

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    any_upd |=> !any_upd);

  a_r10_strobe_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || stop_i) |=> !any_upd);

  a_r11_no_byte_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid_i |=> !any_upd);

  for (genvar s = 0; s < NSYN; s++) begin : g_hold
    a_r4_main_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !main_upd_o[s] |-> $stable({main_mode_o[s], b_count_o[s], a_count_o[s]}));
    a_r4_ref_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_upd_o[s] |-> $stable({ref_mode_o[s], ref_div_o[s]}));
  end
endmodule

bind synth_ctrl_bank sc_checker i_chk (.*);

// File: tb/test_synth_ctrl_bank.sv
module test_synth_ctrl_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, byte_valid_i = 1'b0;
  logic [7:0] byte_data_i = '0;
  logic [2:0] strap_i = '0;
  logic byte_ready_o;
  logic [1:0][6:0]  a_count_o;
  logic [1:0][10:0] b_count_o;
  logic [1:0][1:0]  main_mode_o;
  logic [1:0][14:0] ref_div_o;
  logic [1:0][4:0]  ref_mode_o;
  logic [1:0] main_upd_o, ref_upd_o;

  int checks = 0;
  int errors = 0;
  logic [23:0] mdl [4];

  always #4 clk = ~clk;

  synth_ctrl_bank i_synth_ctrl_bank (.*);

  function automatic logic [7:0] addr_of(input logic [2:0] c);
    case (c)
      3'd0: return 8'hC2;
      3'd1: return 8'hC0;
      3'd2: return 8'hC4;
      3'd3: return 8'hC0;
      default: return 8'hC6;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mask bit k = register with select code k
  task automatic check_state(input string req, input logic [3:0] exp_mask);
    chk(req, {28'd0, main_upd_o[0], ref_upd_o[0], main_upd_o[1], ref_upd_o[1]}, {28'd0, exp_mask});
    for (int s = 0; s < 2; s++) begin
      logic [23:0] mw, rw;
      mw = mdl[s == 0 ? 3 : 1];
      rw = mdl[s == 0 ? 2 : 0];
      chk(req, {12'd0, main_mode_o[s], b_count_o[s], a_count_o[s]}, {12'd0, mw[23:4]});
      chk(req, {12'd0, ref_mode_o[s], ref_div_o[s]}, {12'd0, rw[21:2]});
    end
  endtask

  task automatic do_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask
  task automatic do_stop();
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] b);
    byte_valid_i = 1'b1; byte_data_i = b; @(negedge clk); byte_valid_i = 1'b0;
  endtask

  task automatic send_word(input string req, input logic [23:0] w, input bit commit);
    send_byte(w[23:16]); check_state(req, 4'b0);
    send_byte(w[15:8]);  check_state(req, 4'b0);
    send_byte(w[7:0]);
    if (commit) begin
      mdl[w[1:0]] = w;
      check_state(req, 4'b1 << w[1:0]);
    end else check_state(req, 4'b0);
    @(negedge clk); check_state(req, 4'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    for (int k = 0; k < 4; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 4'b0);
    chk("R1", {31'd0, byte_ready_o}, 32'd1);

    // R2: every strap code with its own address
    for (int c = 0; c < 8; c++) begin
      strap_i = 3'(c);
      do_start(); send_byte(addr_of(3'(c)));
      send_word("R2", {$urandom}[23:0], 1'b1);
      do_stop();
    end

    // R3: wrong address, bytes ignored
    strap_i = 3'd0;
    do_start(); send_byte(8'hC0);
    send_word("R3", 24'hFFFFFF, 1'b0);
    send_word("R3", 24'h123456, 1'b0);
    do_stop();

    // R4/R5/R6: directed field patterns to all four registers
    do_start(); send_byte(8'hC2);
    send_word("R5", {2'b10, 11'h7FF, 7'h00, 2'b11, 2'b11}, 1'b1);
    send_word("R5", {2'b01, 11'h000, 7'h7F, 2'b00, 2'b01}, 1'b1);
    send_word("R6", {2'b11, 5'h15, 15'h4000, 2'b10}, 1'b1);
    send_word("R6", {2'b00, 5'h0A, 15'h0003, 2'b00}, 1'b1);
    do_stop();

    // R7: stop after two bytes discards the partial word
    do_start(); send_byte(8'hC2);
    send_byte(8'hAA); send_byte(8'hBB);
    do_stop(); check_state("R7", 4'b0);
    send_byte(8'hCF); check_state("R7", 4'b0);
    @(negedge clk); check_state("R7", 4'b0);
    do_start(); send_byte(8'hC2);
    send_word("R7", 24'h5A5A5B, 1'b1);
    do_stop();

    // R9: several words in one transaction
    do_start(); send_byte(8'hC2);
    send_word("R9", 24'h0F0F03, 1'b1);
    send_word("R9", 24'hF0F0F1, 1'b1);
    send_word("R9", 24'h3C3C3C, 1'b1);
    do_stop();

    // R10: stop with the third byte, then start with a byte
    do_start(); send_byte(8'hC2);
    send_byte(8'h11); send_byte(8'h22);
    byte_valid_i = 1'b1; byte_data_i = 8'h37; stop_i = 1'b1;
    @(negedge clk); byte_valid_i = 1'b0; stop_i = 1'b0;
    check_state("R10", 4'b0);
    @(negedge clk); check_state("R10", 4'b0);
    byte_valid_i = 1'b1; byte_data_i = 8'h99; start_i = 1'b1;
    @(negedge clk); byte_valid_i = 1'b0; start_i = 1'b0;
    send_byte(8'hC2);
    send_word("R10", 24'h765432, 1'b1);
    do_stop();

    // R11: bytes with no open transaction
    send_word("R11", 24'hC2C2C3, 1'b0);

    // random mix
    for (int it = 0; it < 80; it++) begin
      int mode;
      logic [2:0] c;
      logic [23:0] w;
      mode = int'($urandom % 8);
      c = 3'($urandom);
      w = 24'($urandom);
      strap_i = c;
      do_start();
      if (mode == 0) begin
        send_byte(addr_of(c) ^ 8'h01);
        send_word("R3", w, 1'b0);
      end else if (mode == 1) begin
        send_byte(addr_of(c));
        send_byte(w[23:16]);
        if ($urandom % 2 == 1) send_byte(w[15:8]);
        check_state("R7", 4'b0);
      end else begin
        send_byte(addr_of(c));
        send_word("R4", w, 1'b1);
        if (mode > 5) send_word("R9", 24'($urandom), 1'b1);
      end
      do_stop();
      check_state("R7", 4'b0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule